// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each received Ethernet frame, whether the frame is kept and which of eight receive channels gets it. Upstream logic presents the 48-bit destination address with a one-cycle strobe. On the next clock edge the block registers a verdict: an accept flag and a 3-bit channel number. A small verdict state (reject, promiscuous, broadcast, multicast, unicast) is held in a register until the next strobe.

The configuration word carries a promiscuous enable and channel, a broadcast enable and channel, and a multicast enable and channel. A 64-entry multicast hash table arrives as two 32-bit words. Unicast frames are checked against the station address and gated by an 8-bit per-channel enable mask, using a separately supplied unicast channel.

Verdict states: `V_REJECT` (nothing matched), `V_PROMISC`, `V_BCAST`, `V_MCAST`, `V_UCAST`. Transitions:
- Reset enters `V_REJECT`.
- A strobe moves to the state the classifier selects.
- With no strobe, the register holds its state.

Top module: `rx_dest_filter`

## Requirements
- R1: `res_valid_o` is 1 in exactly the cycle after a cycle with `addr_valid_i` high, and 0 otherwise.
- R2: With cfg bit 21 set, every frame is accepted on the channel in cfg bits 18:16, whatever its address.
- R3: With promiscuous off, the all-ones address is broadcast. If cfg bit 13 is set it is accepted on the channel in cfg bits 10:8. If bit 13 is clear it is rejected, even when multicast acceptance would pass it.
- R4: With promiscuous off, a non-broadcast address whose bit 40 is 1 is multicast. Bit 40 is the least significant bit of the first octet, which is `dst_addr_i[47:40]`. Such a frame is rejected when cfg bit 5 is clear. Otherwise it is accepted on the channel in cfg bits 2:0 exactly when its hash table bit is 1.
- R5: The hash is the XOR of the eight 6-bit slices `dst_addr_i[6k+5:6k]`, k = 0..7. Hash values 0..31 select bit `hash` of `hash_lo_i`, and values 32..63 select bit `hash-32` of `hash_hi_i`. With both words all ones, every multicast frame passes the table.
- R6: A unicast address (bit 40 = 0) equal to `station_addr_i` is accepted on `ucast_chan_i` only when bit `ucast_chan_i` of `ucast_mask_i` is 1. A unicast address that differs from the station address is rejected.
- R7: A rejected frame yields `accept_o` = 0 and `chan_o` = 0.
- R8: With no strobe, `accept_o` and `chan_o` keep their values, whatever the other inputs do.
- R9: After reset, `res_valid_o`, `accept_o` and `chan_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid_i | input | 1 | Destination address strobe |
| dst_addr_i | input | 48 | Destination address; first octet in bits 47:40 |
| station_addr_i | input | 48 | Own station address |
| cfg_i | input | 32 | Enables and per-class channel numbers |
| hash_lo_i | input | 32 | Hash table entries 0..31 |
| hash_hi_i | input | 32 | Hash table entries 32..63 |
| ucast_mask_i | input | 8 | Per-channel unicast enable |
| ucast_chan_i | input | 3 | Channel for unicast matches |
| res_valid_o | output | 1 | Verdict update strobe |
| accept_o | output | 1 | Frame accepted |
| chan_o | output | 3 | Target channel, 0 on reject |

## Verification
All 64 hash values are swept. Each value uses a one-hot table and an address built to fold onto that value, alongside a neighbouring value that must miss. A wrong slice order, a swapped table half or an off-by-one index would therefore accept the wrong frames. The bench drives a broadcast address with broadcast disabled while multicast is enabled and the tables are all ones. A design that tested the group bit before the all-ones check would accept that frame. Unicast runs every channel under a mask that enables only that channel and under a mask that disables only that channel, which catches a mask indexed by the wrong channel. Rejected verdicts must show channel 0, and held outputs must stay put while the inputs change without a strobe.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
    localparam int ADDR_W      = 48;
    localparam int CHAN_W      = 3;
    localparam int HASH_W      = 6;
    localparam int CFG_W       = 32;
    localparam int PROM_EN_BIT = 21;
    localparam int PROM_CH_LSB = 16;
    localparam int BC_EN_BIT   = 13;
    localparam int BC_CH_LSB   = 8;
    localparam int MC_EN_BIT   = 5;
    localparam int MC_CH_LSB   = 0;
    localparam int GROUP_BIT   = 40;

    typedef enum logic [2:0] {
        V_REJECT  = 3'd0,
        V_PROMISC = 3'd1,
        V_BCAST   = 3'd2,
        V_MCAST   = 3'd3,
        V_UCAST   = 3'd4
    } verdict_e;
endpackage

// File: rtl/rxaf_hash_fold.sv
module rxaf_hash_fold #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [HASH_W-1:0] hash_o
);
    localparam int NSLICE = (ADDR_W + HASH_W - 1) / HASH_W;
    localparam int PAD_W  = NSLICE * HASH_W;

    logic [PAD_W-1:0] padded;

    generate
        if (PAD_W > ADDR_W) begin : g_pad
            assign padded = {{(PAD_W-ADDR_W){1'b0}}, addr_i};
        end else begin : g_nopad
            assign padded = addr_i;
        end
    endgenerate

    always_comb begin
        hash_o = '0;
        for (int k = 0; k < NSLICE; k++) begin
            hash_o = hash_o ^ padded[k*HASH_W +: HASH_W];
        end
    end
endmodule

// File: rtl/rxaf_hash_lookup.sv
module rxaf_hash_lookup #(
    parameter int HASH_W = 6
) (
    input  logic [HASH_W-1:0]            hash_i,
    input  logic [(1<<(HASH_W-1))-1:0]   tbl_lo_i,
    input  logic [(1<<(HASH_W-1))-1:0]   tbl_hi_i,
    output logic                         hit_o
);
    localparam int IDX_W = HASH_W - 1;

    logic [IDX_W-1:0] idx;
    assign idx = hash_i[IDX_W-1:0];

    always_comb begin
        if (hash_i[HASH_W-1]) hit_o = tbl_hi_i[idx];
        else                  hit_o = tbl_lo_i[idx];
    end
endmodule

// File: rtl/rxaf_classify.sv
module rxaf_classify
    import rxaf_pkg::*;
#(
    parameter int ADDR_W   = rxaf_pkg::ADDR_W,
    parameter int CHAN_W   = rxaf_pkg::CHAN_W,
    parameter int CFG_W    = rxaf_pkg::CFG_W,
    parameter int NUM_CHAN = 1 << CHAN_W
) (
    input  logic [ADDR_W-1:0]   dst_i,
    input  logic [ADDR_W-1:0]   station_i,
    input  logic [CFG_W-1:0]    cfg_i,
    input  logic                hash_hit_i,
    input  logic [NUM_CHAN-1:0] ucast_mask_i,
    input  logic [CHAN_W-1:0]   ucast_chan_i,
    output verdict_e            verdict_o,
    output logic [CHAN_W-1:0]   chan_o
);
    logic is_bcast;
    logic is_group;
    logic is_own;

    assign is_bcast = &dst_i;
    assign is_group = dst_i[GROUP_BIT];
    assign is_own   = (dst_i == station_i);

    always_comb begin
        verdict_o = V_REJECT;
        chan_o    = '0;
        if (cfg_i[PROM_EN_BIT]) begin
            verdict_o = V_PROMISC;
            chan_o    = cfg_i[PROM_CH_LSB +: CHAN_W];
        end else if (is_bcast) begin
            if (cfg_i[BC_EN_BIT]) begin
                verdict_o = V_BCAST;
                chan_o    = cfg_i[BC_CH_LSB +: CHAN_W];
            end
        end else if (is_group) begin
            if (cfg_i[MC_EN_BIT] && hash_hit_i) begin
                verdict_o = V_MCAST;
                chan_o    = cfg_i[MC_CH_LSB +: CHAN_W];
            end
        end else if (is_own && ucast_mask_i[ucast_chan_i]) begin
            verdict_o = V_UCAST;
            chan_o    = ucast_chan_i;
        end
    end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxaf_pkg::*;
#(
    parameter int ADDR_W   = rxaf_pkg::ADDR_W,
    parameter int CHAN_W   = rxaf_pkg::CHAN_W,
    parameter int HASH_W   = rxaf_pkg::HASH_W,
    parameter int CFG_W    = rxaf_pkg::CFG_W,
    parameter int NUM_CHAN = 1 << CHAN_W,
    parameter int TBL_W    = 1 << (HASH_W - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_valid_i,
    input  logic [ADDR_W-1:0]   dst_addr_i,
    input  logic [ADDR_W-1:0]   station_addr_i,
    input  logic [CFG_W-1:0]    cfg_i,
    input  logic [TBL_W-1:0]    hash_lo_i,
    input  logic [TBL_W-1:0]    hash_hi_i,
    input  logic [NUM_CHAN-1:0] ucast_mask_i,
    input  logic [CHAN_W-1:0]   ucast_chan_i,
    output logic                res_valid_o,
    output logic                accept_o,
    output logic [CHAN_W-1:0]   chan_o
);
    logic [HASH_W-1:0] hash;
    logic              hash_hit;
    verdict_e          verdict_d, verdict_q;
    logic [CHAN_W-1:0] chan_d, chan_q;
    logic              valid_q;

    rxaf_hash_fold #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) fold_i (
        .addr_i (dst_addr_i),
        .hash_o (hash)
    );

    rxaf_hash_lookup #(.HASH_W(HASH_W)) lookup_i (
        .hash_i   (hash),
        .tbl_lo_i (hash_lo_i),
        .tbl_hi_i (hash_hi_i),
        .hit_o    (hash_hit)
    );

    rxaf_classify #(
        .ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .CFG_W(CFG_W), .NUM_CHAN(NUM_CHAN)
    ) classify_i (
        .dst_i        (dst_addr_i),
        .station_i    (station_addr_i),
        .cfg_i        (cfg_i),
        .hash_hit_i   (hash_hit),
        .ucast_mask_i (ucast_mask_i),
        .ucast_chan_i (ucast_chan_i),
        .verdict_o    (verdict_d),
        .chan_o       (chan_d)
    );

    // verdict state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= V_REJECT;
            chan_q    <= '0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= addr_valid_i;
            if (addr_valid_i) begin
                verdict_q <= verdict_d;
                chan_q    <= chan_d;
            end
        end
    end

    // outputs from verdict state
    always_comb begin
        res_valid_o = valid_q;
        accept_o    = 1'b0;
        chan_o      = '0;
        unique case (verdict_q)
            V_REJECT: begin
                accept_o = 1'b0;
                chan_o   = '0;
            end
            V_PROMISC, V_BCAST, V_MCAST, V_UCAST: begin
                accept_o = 1'b1;
                chan_o   = chan_q;
            end
            default: begin
                accept_o = 1'b0;
                chan_o   = '0;
            end
        endcase
    end
endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_valid_i,
    input logic [47:0] dst_addr_i,
    input logic [31:0] cfg_i,
    input logic        res_valid_o,
    input logic        accept_o,
    input logic [2:0]  chan_o
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_i |=> res_valid_o); // R1
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid_i |=> !res_valid_o); // R1
    AST_PROMISC_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && cfg_i[21]) |=> (accept_o && chan_o == $past(cfg_i[18:16]))); // R2
    AST_BCAST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && !cfg_i[21] && (&dst_addr_i) && cfg_i[13])
        |=> (accept_o && chan_o == $past(cfg_i[10:8]))); // R3
    AST_BCAST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && !cfg_i[21] && (&dst_addr_i) && !cfg_i[13]) |=> !accept_o); // R3
    AST_MCAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && !cfg_i[21] && !(&dst_addr_i) && dst_addr_i[40] && !cfg_i[5])
        |=> !accept_o); // R4
    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_o |-> (chan_o == 3'd0)); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid_i |=> ($stable(accept_o) && $stable(chan_o))); // R8
endmodule

bind rx_dest_filter rxaf_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_valid_i (addr_valid_i),
    .dst_addr_i   (dst_addr_i),
    .cfg_i        (cfg_i),
    .res_valid_o  (res_valid_o),
    .accept_o     (accept_o),
    .chan_o       (chan_o)
);

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid_i = 1'b0;
    logic [47:0] dst_addr_i = '0;
    logic [47:0] station_addr_i = '0;
    logic [31:0] cfg_i = '0;
    logic [31:0] hash_lo_i = '0;
    logic [31:0] hash_hi_i = '0;
    logic [7:0]  ucast_mask_i = '0;
    logic [2:0]  ucast_chan_i = '0;
    logic        res_valid_o;
    logic        accept_o;
    logic [2:0]  chan_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [47:0] seed = 48'h5A3C_9E17_2B64;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_dest_filter dut_i (
        .clk(clk), .rst_n(rst_n), .addr_valid_i(addr_valid_i),
        .dst_addr_i(dst_addr_i), .station_addr_i(station_addr_i), .cfg_i(cfg_i),
        .hash_lo_i(hash_lo_i), .hash_hi_i(hash_hi_i), .ucast_mask_i(ucast_mask_i),
        .ucast_chan_i(ucast_chan_i), .res_valid_o(res_valid_o),
        .accept_o(accept_o), .chan_o(chan_o)
    );

    function automatic logic [5:0] fold6(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int k = 0; k < 8; k++) h = h ^ a[k*6 +: 6];
        return h;
    endfunction

    function automatic logic [47:0] next_rand(input logic [47:0] s);
        logic [47:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        if (x == 0) x = 48'h1;
        return x;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // presents one address and compares the registered verdict
    task automatic present(input string req, input logic [47:0] a,
                           input logic exp_acc, input logic [2:0] exp_ch);
        @(negedge clk);
        dst_addr_i = a;
        addr_valid_i = 1'b1;
        @(negedge clk);
        addr_valid_i = 1'b0;
        check({req, " valid"}, {31'd0, res_valid_o}, 32'd1);
        check({req, " accept"}, {31'd0, accept_o}, {31'd0, exp_acc});
        check({req, " chan"}, {29'd0, chan_o}, {29'd0, exp_ch});
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic [47:0] a;
        logic [5:0]  f;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 valid", {31'd0, res_valid_o}, 32'd0);
        check("R9 accept", {31'd0, accept_o}, 32'd0);
        check("R9 chan", {29'd0, chan_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", {31'd0, res_valid_o}, 32'd0);

        // R2: promiscuous on every channel, arbitrary addresses
        for (int c = 0; c < 8; c++) begin
            seed = next_rand(seed);
            cfg_i = 32'd0;
            cfg_i[21] = 1'b1;
            cfg_i[18:16] = c[2:0];
            cfg_i[10:8] = ~c[2:0];
            present("R2 promisc", seed, 1'b1, c[2:0]);
        end
        present("R2 promisc bcast", {48{1'b1}}, 1'b1, 3'd7);

        // R3: broadcast enabled on each channel
        for (int c = 0; c < 8; c++) begin
            cfg_i = 32'd0;
            cfg_i[13] = 1'b1;
            cfg_i[10:8] = c[2:0];
            cfg_i[2:0] = ~c[2:0];
            cfg_i[5] = 1'b1;
            present("R3 bcast", {48{1'b1}}, 1'b1, c[2:0]);
        end
        // R3: broadcast disabled while multicast would pass
        cfg_i = 32'd0;
        cfg_i[5] = 1'b1;
        cfg_i[2:0] = 3'd5;
        cfg_i[10:8] = 3'd3;
        hash_lo_i = '1;
        hash_hi_i = '1;
        present("R3 bcast blocked", {48{1'b1}}, 1'b0, 3'd0);

        // R4/R5: sweep every hash value with a one-hot table
        for (int h = 0; h < 64; h++) begin
            cfg_i = 32'd0;
            cfg_i[5] = 1'b1;
            cfg_i[2:0] = h[2:0];
            hash_lo_i = (h < 32) ? (32'd1 << h) : 32'd0;
            hash_hi_i = (h >= 32) ? (32'd1 << (h - 32)) : 32'd0;
            seed = next_rand(seed);
            a = seed;
            a[47] = 1'b0;
            a[40] = 1'b1;
            a[5:0] = 6'd0;
            f = fold6(a);
            a[5:0] = h[5:0] ^ f;
            present("R5 hash hit", a, 1'b1, h[2:0]);
            a[0] = ~a[0];
            present("R5 hash miss", a, 1'b0, 3'd0);
        end
        // R4: multicast disabled with all-ones table
        hash_lo_i = '1;
        hash_hi_i = '1;
        cfg_i = 32'd0;
        cfg_i[2:0] = 3'd6;
        for (int i = 0; i < 4; i++) begin
            seed = next_rand(seed);
            a = seed;
            a[47] = 1'b0;
            a[40] = 1'b1;
            present("R4 mcast off", a, 1'b0, 3'd0);
        end
        // R5: all-ones table passes any multicast
        cfg_i[5] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            seed = next_rand(seed);
            a = seed;
            a[47] = 1'b0;
            a[40] = 1'b1;
            present("R5 all ones", a, 1'b1, 3'd6);
        end

        // R6: unicast per channel, enabling and disabling that channel only
        cfg_i = 32'd0;
        cfg_i[5] = 1'b1;
        cfg_i[13] = 1'b1;
        for (int c = 0; c < 8; c++) begin
            seed = next_rand(seed);
            a = seed;
            a[40] = 1'b0;
            station_addr_i = a;
            ucast_chan_i = c[2:0];
            ucast_mask_i = 8'd1 << c;
            present("R6 ucast on", a, 1'b1, c[2:0]);
            ucast_mask_i = ~(8'd1 << c);
            present("R6 ucast masked", a, 1'b0, 3'd0);
            ucast_mask_i = '1;
            a[23] = ~a[23];
            present("R7 ucast mismatch", a, 1'b0, 3'd0);
        end

        // R8: hold without strobe while inputs change
        station_addr_i = 48'h0000_1234_5678;
        ucast_mask_i = '1;
        ucast_chan_i = 3'd4;
        present("R8 setup", 48'h0000_1234_5678, 1'b1, 3'd4);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cfg_i = 32'd0;
            cfg_i[21] = 1'b1;
            cfg_i[18:16] = i[2:0];
            dst_addr_i = {48{1'b1}};
            check("R8 hold accept", {31'd0, accept_o}, 32'd1);
            check("R8 hold chan", {29'd0, chan_o}, 32'd4);
            check("R1 no strobe", {31'd0, res_valid_o}, 32'd0);
        end

        done = 1'b1;
        report();
    end
endmodule